// File: doc/BRIEF.md
# Latched Output Stage with Blanking Control

This block sits after a wide serial-to-parallel register in a display column driver. When a separate strobe falls, it copies the parallel register word into a holding latch. The held word then reaches the output pins through a small override stage. Software and timing logic can blank the whole row low or high, or float every pin. None of these actions disturbs the held word. The next line of data can therefore be shifted in while the current one is being displayed.

The strobe, the two blanking controls and the float control are treated as slow signals. A system clock that is faster than the shortest strobe pulse samples them. The capture happens on the first clock edge that sees the strobe low after it was high. The outputs come out as one data vector and one shared enable. A wrapper at the pad level turns these into the tri-state drivers.

Top module: `latched_drive_stage`

## Requirements
- R1: On the first rising clock edge at which `strobe_n` is sampled low, having been sampled high at the previous edge, the held word takes the value of `col_bits` at that edge. A strobe that stays low for one clock period is enough.
- R2: At every other edge the held word keeps its value. This covers changes on `col_bits` while `strobe_n` is high, and `strobe_n` staying low over several edges.
- R3: While `float_req` is 1, `pin_en` is 0 and `pin_val` is all zeros, whatever the other controls are.
- R4: While `float_req` is 0 and `blank_lo_n` is 0, `pin_en` is 1 and `pin_val` is all zeros, even if `blank_hi_n` is also 0.
- R5: While `float_req` is 0, `blank_lo_n` is 1 and `blank_hi_n` is 0, `pin_en` is 1 and `pin_val` is all ones.
- R6: While `float_req` is 0 and both blanking inputs are 1, `pin_en` is 1 and each bit of `pin_val` equals the same bit of the held word, without inversion.
- R7: Reset does not clear the held word. A `strobe_n` that is already low when reset ends is not taken as a falling edge.
- R8: The overrides in R3 to R5 leave the held word untouched. When they are released, the word captured before them reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any strobe pulse |
| rst_n | input | 1 | Asynchronous active-low reset of the edge detector |
| col_bits | input | WIDTH | Parallel word from the shift register |
| strobe_n | input | 1 | Active-low latch strobe; capture on its falling edge |
| blank_lo_n | input | 1 | Active-low force of all outputs to 0 |
| blank_hi_n | input | 1 | Active-low force of all outputs to 1 |
| float_req | input | 1 | Active-high request to release all outputs |
| pin_val | output | WIDTH | Value each output drives when enabled |
| pin_en | output | 1 | Shared output enable; 0 means every output floats |

## Verification
The assertions check on every cycle that the held word changes only on a detected strobe fall and then matches the input word. They also check that the output vector and enable always follow the priority of float, then low blank, then high blank, then data. Only the bench scenarios can show the effects that span several steps. These are: a word surviving a long blanking interval and a reset, a strobe held low across reset release that captures nothing, and data patterns with mixed bits reaching the pins in the right bit order.

// File: rtl/latched_drive_stage.sv
module latched_drive_stage #(
  parameter int WIDTH = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] col_bits,
  input  logic             strobe_n,
  input  logic             blank_lo_n,
  input  logic             blank_hi_n,
  input  logic             float_req,
  output logic [WIDTH-1:0] pin_val,
  output logic             pin_en
);

  logic             strobe_seen_hi;
  logic             grab;
  logic [WIDTH-1:0] held;

  // Reset to "already low" so a strobe held low across reset is not an edge.
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strobe_seen_hi <= 1'b0;
    else        strobe_seen_hi <= strobe_n;

  assign grab = strobe_seen_hi & ~strobe_n;

  always_ff @(posedge clk)
    if (grab) held <= col_bits;

  assign pin_en  = ~float_req;
  assign pin_val = float_req   ? '0 :
                   !blank_lo_n ? '0 :
                   !blank_hi_n ? '1 : held;

  AST_CAPTURE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_seen_hi && !strobe_n) |=> (held == $past(col_bits)));  // R1
  AST_HOLD_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_seen_hi && !strobe_n) |=> $stable(held));  // R2
  AST_FLOAT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    float_req |-> (!pin_en && pin_val == '0));  // R3
  AST_LOW_BLANK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!float_req && !blank_lo_n) |-> (pin_en && pin_val == '0));  // R4
  AST_HIGH_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!float_req && blank_lo_n && !blank_hi_n) |-> (pin_en && pin_val == '1));  // R5
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!float_req && blank_lo_n && blank_hi_n) |-> (pin_en && pin_val == held));  // R6

endmodule

// File: tb/sim_latched_drive_stage.sv
module sim_latched_drive_stage;
  localparam int W = 192;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] col_bits = '0;
  logic         strobe_n = 1'b1;
  logic         blank_lo_n = 1'b0;
  logic         blank_hi_n = 1'b1;
  logic         float_req = 1'b0;
  logic [W-1:0] pin_val;
  logic         pin_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  latched_drive_stage #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .col_bits(col_bits), .strobe_n(strobe_n),
    .blank_lo_n(blank_lo_n), .blank_hi_n(blank_hi_n), .float_req(float_req),
    .pin_val(pin_val), .pin_en(pin_en)
  );

  localparam logic [W-1:0] PAT_A = {24{8'hA5}};
  localparam logic [W-1:0] PAT_B = {W{1'b0}} | 192'h1 | (192'h1 << (W-1));
  localparam logic [W-1:0] PAT_C = {12{16'h0FF0}};
  localparam logic [W-1:0] PAT_D = {48{4'h9}};

  // {float_req, blank_lo_n, blank_hi_n, kind}: kind 0 float, 1 zeros, 2 ones, 3 data
  localparam logic [4:0] VEC [8] = '{
    {3'b000, 2'd1}, {3'b001, 2'd1}, {3'b010, 2'd2}, {3'b011, 2'd3},
    {3'b100, 2'd0}, {3'b101, 2'd0}, {3'b110, 2'd0}, {3'b111, 2'd0}
  };

  task automatic check(input string tag, input logic [W-1:0] exp_v, input logic exp_e);
    checks++;
    if (pin_val !== exp_v || pin_en !== exp_e) begin
      errors++;
      $display("FAIL %s: pin_val=%h pin_en=%b expected pin_val=%h pin_en=%b",
               tag, pin_val, pin_en, exp_v, exp_e);
    end
  endtask

  task automatic strobe(input logic [W-1:0] word);
    @(negedge clk);
    col_bits = word;
    strobe_n = 1'b0;
    @(negedge clk);
    strobe_n = 1'b1;
    col_bits = ~word;
    @(negedge clk);
  endtask

  task automatic show_data();
    float_req = 1'b0; blank_lo_n = 1'b1; blank_hi_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset state with low blank", '0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    strobe(PAT_A);
    show_data();
    check("R1 capture pattern A", PAT_A, 1'b1);

    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] ev;
      @(negedge clk);
      {float_req, blank_lo_n, blank_hi_n} = VEC[i][4:2];
      #1;
      case (VEC[i][1:0])
        2'd0: ev = '0;
        2'd1: ev = '0;
        2'd2: ev = '1;
        default: ev = PAT_A;
      endcase
      check($sformatf("R3/R4/R5/R6 vector %0d", i), ev, VEC[i][1:0] != 2'd0);
    end

    @(negedge clk);
    show_data();
    check("R8 data back after overrides", PAT_A, 1'b1);

    strobe(PAT_B);
    check("R6 end bits no inversion", PAT_B, 1'b1);

    @(negedge clk); col_bits = PAT_C;
    repeat (3) @(negedge clk);
    check("R2 input change with strobe high", PAT_B, 1'b1);

    col_bits = PAT_C; strobe_n = 1'b0;
    @(negedge clk); col_bits = PAT_D;
    repeat (3) @(negedge clk);
    check("R2 strobe held low captures once", PAT_C, 1'b1);
    strobe_n = 1'b1;
    @(negedge clk);

    blank_lo_n = 1'b0; blank_hi_n = 1'b0;
    strobe(PAT_D);
    check("R4 low blank beats high blank", '0, 1'b1);
    blank_lo_n = 1'b1;
    #1;
    check("R5 high blank", '1, 1'b1);
    blank_hi_n = 1'b1;
    #1;
    check("R8 capture under blank shows after", PAT_D, 1'b1);

    @(negedge clk);
    col_bits = PAT_A; strobe_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset keeps word, low strobe no capture", PAT_D, 1'b1);
    strobe_n = 1'b1;
    strobe(PAT_C);
    check("R1 capture after reset", PAT_C, 1'b1);

    float_req = 1'b1;
    #1;
    check("R3 float", '0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule